// File: doc/BRIEF.md
# Fault-Injectable Register Bank

A small synchronous register bank with one write port and one read port. Its storage cells and read bus can be made to misbehave on command. The purpose is to check whether a test program detects stored-data defects. Software or a test sequencer programs one cell fault and, separately, one read-bus fault. Each fault can be switched on or off without disturbing the stored contents.

The cell fault targets one bit of one cell, called the victim. Its behaviour is one of the following:

- The bit is held at a fixed level.
- The bit refuses one direction of transition.
- The bit is disturbed when a second bit, the aggressor, is written with a transition in a programmed direction.

The bus fault acts on the read data path. It either pins one line to a constant, or merges two lines as a wired-AND or a wired-OR. With both faults disabled, the bank is an ideal register file with a one-cycle read.

Top module: `fault_reg_bank`

## Requirements
- R1: While `rst_ni` is low, every cell and `rd_data_o` are cleared to zero.
- R2: With `flt_en_i` and `bus_en_i` both low, a write stores `wr_data_i` at `wr_addr_i` on the clock edge. `rd_data_o` shows the contents of `rd_addr_i` one clock after the address is presented.
- R3: A read of the cell that is written in the same cycle returns that cell's previous contents.
- R4: With `flt_kind_i` = 0 (stuck-0) or 1 (stuck-1), a read of cell `flt_addr_i` returns bit `flt_bit_i` as 0 or 1 respectively, whatever was written.
- R5: With `flt_kind_i` = 2, a write that would change victim bit `flt_bit_i` from 0 to 1 leaves it at 0. A write from 1 to 0 still works.
- R6: With `flt_kind_i` = 3, a write that would change the victim bit from 1 to 0 leaves it at 1. A write from 0 to 1 still works.
- R7: With `flt_kind_i` = 4 (coupled inversion), a write to cell `agg_addr_i` that changes bit `agg_bit_i` to the level `agg_rise_i` inverts the victim bit. The inversion is applied after any write to the victim cell in the same cycle.
- R8: With `flt_kind_i` = 5 (coupled set), the same trigger as in R7 forces the victim bit to `cpl_val_i`.
- R9: A coupling fault does not trigger if the aggressor bit is written with an unchanged value, or if it changes toward the level opposite to `agg_rise_i`.
- R10: With `bus_en_i` high and `bus_kind_i` = 0 or 1, read line `bus_line_a_i` is forced to 0 or 1 respectively.
- R11: With `bus_en_i` high and `bus_kind_i` = 2 or 3, read lines `bus_line_a_i` and `bus_line_b_i` both carry the AND (for 2) or the OR (for 3) of their fault-free values.
- R12: Codes 6 and 7 of `flt_kind_i` have no effect. Fault configuration never alters cells other than the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | WIDTH | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | WIDTH | Registered read data |
| flt_en_i | input | 1 | Enable for the cell fault |
| flt_kind_i | input | 3 | Cell fault kind (codes in R4 to R8) |
| flt_addr_i | input | AW | Victim cell |
| flt_bit_i | input | BW | Victim bit |
| agg_addr_i | input | AW | Aggressor cell |
| agg_bit_i | input | BW | Aggressor bit |
| agg_rise_i | input | 1 | Triggering aggressor level after the transition (1: rising) |
| cpl_val_i | input | 1 | Level forced by the coupled-set fault |
| bus_en_i | input | 1 | Enable for the read-bus fault |
| bus_kind_i | input | 2 | Bus fault kind (codes in R10, R11) |
| bus_line_a_i | input | BW | First affected read line |
| bus_line_b_i | input | BW | Second line for a short |

## Verification
The coupling faults are the hardest to reach from the ports. A trigger needs the aggressor bit to hold the opposite level before a write that flips it in the programmed direction. The victim's change only becomes visible on a later read of a different cell. The stimulus first preloads the aggressor with a known value and writes it in both directions. It then runs bursts of random traffic over all eight cells for each fault kind, so that triggers, non-triggers and victim-equals-aggressor overlaps all occur. A behavioural model in the bench tracks each of these cases.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [2:0] {
    CF_SA0      = 3'd0,
    CF_SA1      = 3'd1,
    CF_TF_RISE  = 3'd2,
    CF_TF_FALL  = 3'd3,
    CF_CPL_INV  = 3'd4,
    CF_CPL_SET  = 3'd5,
    CF_NONE6    = 3'd6,
    CF_NONE7    = 3'd7
  } cell_fault_e;

  typedef enum logic [1:0] {
    BF_STUCK0 = 2'd0,
    BF_STUCK1 = 2'd1,
    BF_AND    = 2'd2,
    BF_OR     = 2'd3
  } bus_fault_e;
endpackage

// File: rtl/fb_cpl_detect.sv
module fb_cpl_detect
  import fb_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AW    = 3,
  parameter int BW    = 3
) (
  input  logic              flt_en_i,
  input  cell_fault_e       flt_kind_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic [AW-1:0]     agg_addr_i,
  input  logic [BW-1:0]     agg_bit_i,
  input  logic              agg_rise_i,
  input  logic              agg_old_i,
  output logic              hit_o
);
  logic agg_new;
  logic kind_cpl;

  assign agg_new  = wr_data_i[agg_bit_i];
  assign kind_cpl = (flt_kind_i == CF_CPL_INV) || (flt_kind_i == CF_CPL_SET);
  // trigger only on a real transition that ends at the programmed level
  assign hit_o = flt_en_i && kind_cpl && wr_en_i && (wr_addr_i == agg_addr_i)
                 && (agg_new != agg_old_i) && (agg_new == agg_rise_i);
endmodule

// File: rtl/fb_cell_next.sv
module fb_cell_next
  import fb_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AW    = 3,
  parameter int BW    = 3,
  parameter int IDX   = 0
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             flt_en_i,
  input  cell_fault_e      flt_kind_i,
  input  logic [AW-1:0]    flt_addr_i,
  input  logic [BW-1:0]    flt_bit_i,
  input  logic             cpl_hit_i,
  input  logic             cpl_val_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [AW-1:0] SELF = AW'(IDX);

  logic is_victim;
  assign is_victim = flt_en_i && (flt_addr_i == SELF);

  always_comb begin
    nxt_o = cur_i;
    if (wr_en_i && (wr_addr_i == SELF)) begin
      nxt_o = wr_data_i;
      if (is_victim && flt_kind_i == CF_TF_RISE && !cur_i[flt_bit_i] && wr_data_i[flt_bit_i])
        nxt_o[flt_bit_i] = 1'b0;
      if (is_victim && flt_kind_i == CF_TF_FALL && cur_i[flt_bit_i] && !wr_data_i[flt_bit_i])
        nxt_o[flt_bit_i] = 1'b1;
    end
    // disturbance lands after the cell's own write
    if (cpl_hit_i && is_victim)
      nxt_o[flt_bit_i] = (flt_kind_i == CF_CPL_INV) ? ~nxt_o[flt_bit_i] : cpl_val_i;
  end
endmodule

// File: rtl/fb_read_path.sv
module fb_read_path
  import fb_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AW    = 3,
  parameter int BW    = 3
) (
  input  logic [WIDTH-1:0] cell_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             flt_en_i,
  input  cell_fault_e      flt_kind_i,
  input  logic [AW-1:0]    flt_addr_i,
  input  logic [BW-1:0]    flt_bit_i,
  input  logic             bus_en_i,
  input  bus_fault_e       bus_kind_i,
  input  logic [BW-1:0]    bus_line_a_i,
  input  logic [BW-1:0]    bus_line_b_i,
  output logic [WIDTH-1:0] val_o
);
  logic wired;

  always_comb begin
    val_o = cell_i;
    wired = 1'b0;
    if (flt_en_i && (rd_addr_i == flt_addr_i)) begin
      if (flt_kind_i == CF_SA0) val_o[flt_bit_i] = 1'b0;
      if (flt_kind_i == CF_SA1) val_o[flt_bit_i] = 1'b1;
    end
    if (bus_en_i) begin
      case (bus_kind_i)
        BF_STUCK0: val_o[bus_line_a_i] = 1'b0;
        BF_STUCK1: val_o[bus_line_a_i] = 1'b1;
        BF_AND: begin
          wired = val_o[bus_line_a_i] & val_o[bus_line_b_i];
          val_o[bus_line_a_i] = wired;
          val_o[bus_line_b_i] = wired;
        end
        default: begin
          wired = val_o[bus_line_a_i] | val_o[bus_line_b_i];
          val_o[bus_line_a_i] = wired;
          val_o[bus_line_b_i] = wired;
        end
      endcase
    end
  end
endmodule

// File: rtl/fault_reg_bank.sv
module fault_reg_bank
  import fb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             flt_en_i,
  input  logic [2:0]       flt_kind_i,
  input  logic [AW-1:0]    flt_addr_i,
  input  logic [BW-1:0]    flt_bit_i,
  input  logic [AW-1:0]    agg_addr_i,
  input  logic [BW-1:0]    agg_bit_i,
  input  logic             agg_rise_i,
  input  logic             cpl_val_i,
  input  logic             bus_en_i,
  input  logic [1:0]       bus_kind_i,
  input  logic [BW-1:0]    bus_line_a_i,
  input  logic [BW-1:0]    bus_line_b_i
);
  cell_fault_e      kind;
  bus_fault_e       bkind;
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] mem_d [DEPTH];
  logic [WIDTH-1:0] rd_cell, rd_val, rd_q;
  logic             cpl_hit;

  assign kind  = cell_fault_e'(flt_kind_i);
  assign bkind = bus_fault_e'(bus_kind_i);

  fb_cpl_detect #(.WIDTH(WIDTH), .AW(AW), .BW(BW)) u_cpl (
    .flt_en_i   (flt_en_i),
    .flt_kind_i (kind),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .agg_addr_i (agg_addr_i),
    .agg_bit_i  (agg_bit_i),
    .agg_rise_i (agg_rise_i),
    .agg_old_i  (mem_q[agg_addr_i][agg_bit_i]),
    .hit_o      (cpl_hit)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    fb_cell_next #(.WIDTH(WIDTH), .AW(AW), .BW(BW), .IDX(i)) u_nxt (
      .cur_i      (mem_q[i]),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .flt_en_i   (flt_en_i),
      .flt_kind_i (kind),
      .flt_addr_i (flt_addr_i),
      .flt_bit_i  (flt_bit_i),
      .cpl_hit_i  (cpl_hit),
      .cpl_val_i  (cpl_val_i),
      .nxt_o      (mem_d[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else         mem_q[i] <= mem_d[i];
    end
  end

  assign rd_cell = mem_q[rd_addr_i];

  fb_read_path #(.WIDTH(WIDTH), .AW(AW), .BW(BW)) u_rd (
    .cell_i       (rd_cell),
    .rd_addr_i    (rd_addr_i),
    .flt_en_i     (flt_en_i),
    .flt_kind_i   (kind),
    .flt_addr_i   (flt_addr_i),
    .flt_bit_i    (flt_bit_i),
    .bus_en_i     (bus_en_i),
    .bus_kind_i   (bkind),
    .bus_line_a_i (bus_line_a_i),
    .bus_line_b_i (bus_line_b_i),
    .val_o        (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_val;
  end

  assign rd_data_o = rd_q;

  p_write_ideal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flt_en_i && wr_en_i) |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

  p_stuck_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_en_i && !bus_en_i && flt_kind_i[2:1] == 2'b00 && rd_addr_i == flt_addr_i)
    |=> rd_data_o[$past(flt_bit_i)] == $past(flt_kind_i[0]));

  p_rise_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_en_i && kind == CF_TF_RISE && wr_en_i && wr_addr_i == flt_addr_i
     && !mem_q[flt_addr_i][flt_bit_i])
    |=> !mem_q[$past(flt_addr_i)][$past(flt_bit_i)]);

  p_cpl_inv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_hit && kind == CF_CPL_INV && !(wr_en_i && wr_addr_i == flt_addr_i))
    |=> mem_q[$past(flt_addr_i)][$past(flt_bit_i)]
        != $past(mem_q[flt_addr_i][flt_bit_i]));

  p_bus_stuck_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !bus_kind_i[1])
    |=> rd_data_o[$past(bus_line_a_i)] == $past(bus_kind_i[0]));

  p_bus_short_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_kind_i[1])
    |=> rd_data_o[$past(bus_line_a_i)] == rd_data_o[$past(bus_line_b_i)]);
endmodule

// File: tb/tb_fault_reg_bank.sv
module tb_fault_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int W = 8;
  localparam int AW = 3;
  localparam int BW = 3;

  logic clk_i = 0, rst_ni = 0;
  logic wr_en_i = 0; logic [AW-1:0] wr_addr_i = 0; logic [W-1:0] wr_data_i = 0;
  logic [AW-1:0] rd_addr_i = 0; logic [W-1:0] rd_data_o;
  logic flt_en_i = 0; logic [2:0] flt_kind_i = 0;
  logic [AW-1:0] flt_addr_i = 0, agg_addr_i = 0;
  logic [BW-1:0] flt_bit_i = 0, agg_bit_i = 0, bus_line_a_i = 0, bus_line_b_i = 0;
  logic agg_rise_i = 0, cpl_val_i = 0, bus_en_i = 0;
  logic [1:0] bus_kind_i = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_reg_bank #(.DEPTH(D), .WIDTH(W)) dut (.*);

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  string cur_req = "R1";
  logic [W-1:0] ref_mem [D];
  logic [W-1:0] exp_rd, r, nw, old;
  logic hit, done = 0;

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) ref_mem[i] = '0;
      exp_rd = '0;
    end else begin
      r = ref_mem[rd_addr_i];
      if (flt_en_i && flt_addr_i == rd_addr_i && flt_kind_i < 3'd2) r[flt_bit_i] = flt_kind_i[0];
      if (bus_en_i) begin
        if (bus_kind_i == 2'd0) r[bus_line_a_i] = 1'b0;
        else if (bus_kind_i == 2'd1) r[bus_line_a_i] = 1'b1;
        else begin
          logic m;
          m = (bus_kind_i == 2'd2) ? (r[bus_line_a_i] & r[bus_line_b_i])
                                   : (r[bus_line_a_i] | r[bus_line_b_i]);
          r[bus_line_a_i] = m; r[bus_line_b_i] = m;
        end
      end
      exp_rd = r;
      hit = flt_en_i && (flt_kind_i == 3'd4 || flt_kind_i == 3'd5) && wr_en_i
            && wr_addr_i == agg_addr_i && wr_data_i[agg_bit_i] != ref_mem[agg_addr_i][agg_bit_i]
            && wr_data_i[agg_bit_i] == agg_rise_i;
      if (wr_en_i) begin
        old = ref_mem[wr_addr_i]; nw = wr_data_i;
        if (flt_en_i && flt_addr_i == wr_addr_i) begin
          if (flt_kind_i == 3'd2 && !old[flt_bit_i] && nw[flt_bit_i]) nw[flt_bit_i] = 1'b0;
          if (flt_kind_i == 3'd3 && old[flt_bit_i] && !nw[flt_bit_i]) nw[flt_bit_i] = 1'b1;
        end
        ref_mem[wr_addr_i] = nw;
      end
      if (hit)
        ref_mem[flt_addr_i][flt_bit_i] = (flt_kind_i == 3'd4) ? ~ref_mem[flt_addr_i][flt_bit_i] : cpl_val_i;
    end
  end

  always @(negedge clk_i) begin
    n_cyc++;
    if (!done) begin
      n_cmp++;
      if (rd_data_o !== exp_rd) begin
        n_bad++;
        $display("FAIL %s t=%0t rd_data_o=%h expected=%h", cur_req, $time, rd_data_o, exp_rd);
      end
    end
    if (n_cyc > 50000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cyc(input logic we, input int wa, input int wd, input int ra);
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = AW'(wa); wr_data_i = W'(wd); rd_addr_i = AW'(ra);
  endtask

  task automatic burst(input int n);
    for (int k = 0; k < n; k++)
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, D-1), $urandom_range(0, 255), $urandom_range(0, D-1));
  endtask

  task automatic set_cell_fault(input int kind);
    @(negedge clk_i);
    flt_en_i = 1; flt_kind_i = 3'(kind);
    flt_addr_i = AW'($urandom_range(0, D-1)); flt_bit_i = BW'($urandom_range(0, W-1));
    agg_addr_i = AW'($urandom_range(0, D-1)); agg_bit_i = BW'($urandom_range(0, W-1));
    agg_rise_i = 1'($urandom_range(0, 1)); cpl_val_i = 1'($urandom_range(0, 1));
  endtask

  initial begin
    // R1: reset state on every address
    cur_req = "R1";
    for (int i = 0; i < 3; i++) @(negedge clk_i);
    rst_ni = 1;
    for (int i = 0; i < D; i++) cyc(0, 0, 0, i);

    cur_req = "R2";
    for (int i = 0; i < D; i++) cyc(1, i, 8'h11 * (i + 1), 0);
    for (int i = 0; i < D; i++) cyc(0, 0, 0, i);
    burst(300);

    // R3: same-cycle write/read of one cell
    cur_req = "R3";
    cyc(1, 2, 8'hA5, 2); cyc(1, 2, 8'h5A, 2); cyc(0, 0, 0, 2);

    // R4: victim cell 3 bit 2
    cur_req = "R4";
    @(negedge clk_i); flt_en_i = 1; flt_kind_i = 3'd0; flt_addr_i = 3; flt_bit_i = 2;
    cyc(1, 3, 8'hFF, 3); cyc(0, 0, 0, 3);
    @(negedge clk_i); flt_kind_i = 3'd1;
    cyc(1, 3, 8'h00, 3); cyc(0, 0, 0, 3);

    // R5: rising blocked, falling still works on cell 5 bit 0
    cur_req = "R5";
    @(negedge clk_i); flt_en_i = 0;
    cyc(1, 5, 8'h01, 5);
    @(negedge clk_i); flt_en_i = 1; flt_kind_i = 3'd2; flt_addr_i = 5; flt_bit_i = 0;
    cyc(1, 5, 8'h00, 5); cyc(1, 5, 8'hFF, 5); cyc(0, 0, 0, 5);

    cur_req = "R6";
    @(negedge clk_i); flt_kind_i = 3'd3;
    cyc(1, 5, 8'h01, 5); cyc(1, 5, 8'h00, 5); cyc(0, 0, 0, 5);

    // R7: aggressor cell 1 bit 4 rising, victim cell 6 bit 7
    cur_req = "R7";
    @(negedge clk_i); flt_en_i = 0;
    cyc(1, 1, 8'h00, 0); cyc(1, 6, 8'h00, 0);
    @(negedge clk_i); flt_en_i = 1; flt_kind_i = 3'd4; flt_addr_i = 6; flt_bit_i = 7;
    agg_addr_i = 1; agg_bit_i = 4; agg_rise_i = 1;
    cyc(1, 1, 8'h10, 6); cyc(0, 0, 0, 6); cyc(0, 0, 0, 6);

    // R9: unchanged and opposite-direction writes leave victim alone
    cur_req = "R9";
    cyc(1, 1, 8'h10, 6); cyc(1, 1, 8'h00, 6); cyc(0, 0, 0, 6); cyc(0, 0, 0, 6);

    cur_req = "R8";
    @(negedge clk_i); flt_kind_i = 3'd5; cpl_val_i = 0;
    cyc(1, 1, 8'h10, 6); cyc(0, 0, 0, 6); cyc(0, 0, 0, 6);

    cur_req = "R10";
    @(negedge clk_i); flt_en_i = 0; bus_en_i = 1; bus_kind_i = 2'd1; bus_line_a_i = 3;
    cyc(1, 0, 8'h00, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    burst(60);

    cur_req = "R11";
    @(negedge clk_i); bus_kind_i = 2'd2; bus_line_a_i = 0; bus_line_b_i = 6;
    cyc(1, 4, 8'h01, 4); cyc(0, 0, 0, 4); cyc(0, 0, 0, 4);
    @(negedge clk_i); bus_kind_i = 2'd3;
    cyc(0, 0, 0, 4); cyc(0, 0, 0, 4);
    burst(60);
    @(negedge clk_i); bus_en_i = 0;

    // random traffic per cell fault kind
    for (int k = 0; k < 8; k++) begin
      case (k)
        0, 1: cur_req = "R4";
        2: cur_req = "R5";
        3: cur_req = "R6";
        4: cur_req = "R7";
        5: cur_req = "R8";
        default: cur_req = "R12";
      endcase
      for (int rep = 0; rep < 4; rep++) begin
        set_cell_fault(k);
        burst(60);
      end
    end

    cur_req = "R12";
    @(negedge clk_i); flt_en_i = 0;
    for (int i = 0; i < D; i++) cyc(0, 0, 0, i);

    @(negedge clk_i); @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule